// File: doc/BRIEF.md
# NAND Command and Address Latch Sequencer

This block drives the latch, enable, strobe and data lines of one NAND flash device for a single bus operation. The host hands it either a command byte or an address request. For a command, the sequencer raises the command latch with chip enable, waits a fixed idle gap, strobes the byte onto the data bus, closes the burst with a terminating zero write, lowers the latch and idles again. It then polls the device ready/busy line until the device is ready or a programmable cycle budget runs out.

An address request carries a 24-bit offset and a two-bit mode that chooses which offset slices go out and in what order. The ordering never sends offset bit 8, because the device takes that bit through its choice of read command rather than as an address bit. Address operations finish once the release gap ends and do not wait for ready. Sideband control flags, such as write protect, follow the latch phase onto the control outputs. For address operations a second flag set is ORed in once the latch line falls.

The host sees a valid/ready handshake, and it is held off until a one-cycle done, timeout or reject pulse.

Top module: `nand_cmd_seq`

## Requirements
- R1: Out of reset and while idle, `req_ready` is 1 and `nand_ce`, `nand_cle`, `nand_ale`, `nand_we`, `nand_pipe_term`, `done`, `timeout` and `rejected` are all 0.
- R2: A command (`req_is_addr`=0) accepted in cycle 0 holds `nand_cle` and `nand_ce` high with no strobe in cycles 0 to 3. It strobes the command byte on `nand_dq` with `nand_we` in cycle 4, then issues a terminating write of 0x00 with `nand_we` and `nand_pipe_term` in cycle 5. `nand_ale` stays low throughout.
- R3: After the terminating write, the latch line falls while `nand_ce` stays high for 4 idle cycles. An address operation with N bytes pulses `done` in cycle 9+N.
- R4: Address mode 2'd1 sends one byte, offset bits 7:0, under `nand_ale`.
- R5: Address mode 2'd2 sends offset bits 16:9 and then bits 23:17, the second zero-extended to 8 bits. Offset bit 8 is never placed on the bus.
- R6: Address mode 2'd3 sends offset bits 7:0, then 16:9, then 23:17.
- R7: An address request with mode 2'd0 is answered by a `rejected` pulse in cycle 0, and `nand_ce`, `nand_we` and the latch lines stay low.
- R8: After the release gap, a command waits 4 idle cycles (cycles 10 to 13) and samples `nand_rb` (1 = ready) in cycle 14. While busy it samples again after every 2 idle cycles. `done` pulses in the cycle after the first ready sample, and `nand_ce` stays high for the whole wait.
- R9: A busy sample taken when the wait has lasted at least `rdy_timeout_cycles` cycles (counting from 0 at cycle 10) ends the operation with a `timeout` pulse in the next cycle, and no `done`.
- R10: During the latch phase `nand_flags` equals `req_flags_latch`. After the latch falls it equals `req_flags_latch` for commands and `req_flags_latch | req_flags_release` for addresses. It is 0 when `nand_ce` is low.
- R11: `req_ready` is 0 from acceptance until the result pulse. At most one of `done`, `timeout` and `rejected` is high, each for a single cycle, and `req_ready` returns the cycle after.
- R12: `nand_we` is only ever high for a single cycle per byte, while `nand_ce` and one latch line are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_is_addr | input | 1 | 1 = address operation, 0 = command operation |
| req_cmd | input | 8 | Command byte |
| req_ofs | input | OFS_W (24) | Address offset |
| req_mode | input | 2 | Address byte-order mode (1, 2 or 3; 0 rejected) |
| req_flags_latch | input | FLAG_W (2) | Flags driven during the latch phase |
| req_flags_release | input | FLAG_W (2) | Flags ORed in after the address latch falls |
| rdy_timeout_cycles | input | TO_W (32) | Ready-wait budget in cycles |
| done | output | 1 | Operation completed pulse |
| timeout | output | 1 | Ready-wait expired pulse |
| rejected | output | 1 | Invalid mode pulse |
| nand_ce | output | 1 | Chip enable |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we | output | 1 | Write strobe |
| nand_pipe_term | output | 1 | Marks the terminating zero write |
| nand_dq | output | 8 | Data bus |
| nand_flags | output | FLAG_W (2) | Sideband control flags |
| nand_rb | input | 1 | Device ready (1) or busy (0) |

## Verification
On every cycle the assertions check the protocol shape of the bus. The strobe appears only under an active latch with enable, the two latch lines never overlap, and the terminating write is zero and is followed by a released latch. The gap counters count down cleanly and the three result pulses exclude one another. The byte values and their order per mode, the absence of offset bit 8, the exact cycle counts of each gap, the polling rhythm and the timeout moment are shown only by the bench. It drives known offsets, flag sets, ready timing and budgets and then compares the captured bus trace against timings it works out for itself.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_PRE, S_BYTE, S_TERM, S_POST, S_WAIT, S_FIN, S_TOUT, S_REJ
   } seq_state_t;

   typedef enum logic [1:0] {
      W_OFF, W_PRE, W_SAMP, W_GAP
   } wait_phase_t;

   localparam logic [1:0] MODE_NONE     = 2'd0;
   localparam logic [1:0] MODE_LOW      = 2'd1;
   localparam logic [1:0] MODE_HIGH     = 2'd2;
   localparam logic [1:0] MODE_FULL     = 2'd3;
   localparam int         BUS_W         = 8;
   localparam logic [7:0] TERM_BYTE     = 8'h00;

   function automatic logic mode_valid(input logic [1:0] m);
      return m != MODE_NONE;
   endfunction
endpackage

// File: rtl/nseq_gap_timer.sv
module nseq_gap_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len_m1,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   if (CNT_W < 1) begin : g_bad_w
      $error("nseq_gap_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= len_m1;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R3: idle gaps shrink by exactly one per cycle once loaded
   a_r3_gap_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/nseq_addr_pick.sv
module nseq_addr_pick #(
   parameter int OFS_W = 24
) (
   input  logic             is_addr,
   input  logic [7:0]       cmd,
   input  logic [OFS_W-1:0] ofs,
   input  logic [1:0]       mode,
   input  logic [1:0]       idx,
   output logic [7:0]       byte_out,
   output logic [1:0]       last_idx
);
   import nseq_pkg::*;

   localparam logic [OFS_W-1:0] USED_MASK = OFS_W'(24'hFFFEFF);

   if (OFS_W < 24) begin : g_bad_ofs
      $error("nseq_addr_pick: OFS_W must be at least 24");
   end

   logic [7:0] sl_low, sl_mid, sl_top;
   logic       unused_ofs;

   assign sl_low     = ofs[7:0];
   assign sl_mid     = ofs[16:9];
   assign sl_top     = {1'b0, ofs[23:17]};
   assign unused_ofs = ^(ofs & ~USED_MASK);

   always_comb begin
      byte_out = cmd;
      last_idx = 2'd0;
      if (is_addr) begin
         unique case (mode)
            MODE_HIGH: begin
               last_idx = 2'd1;
               byte_out = (idx == 2'd0) ? sl_mid : sl_top;
            end
            MODE_FULL: begin
               last_idx = 2'd2;
               case (idx)
                  2'd0:    byte_out = sl_low;
                  2'd1:    byte_out = sl_mid;
                  default: byte_out = sl_top;
               endcase
            end
            default: begin
               last_idx = 2'd0;
               byte_out = sl_low;
            end
         endcase
      end
   end
endmodule

// File: rtl/nseq_rdy_wait.sv
module nseq_rdy_wait #(
   parameter int PRE_GAP  = 4,
   parameter int POLL_GAP = 2,
   parameter int TO_W     = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            rb,
   input  logic [TO_W-1:0] limit,
   output logic            ok,
   output logic            tout
);
   import nseq_pkg::*;

   localparam int GMAX = (PRE_GAP > POLL_GAP) ? PRE_GAP : POLL_GAP;
   localparam int GW   = $clog2(GMAX + 1);

   if (PRE_GAP < 1 || POLL_GAP < 1) begin : g_bad_gap
      $error("nseq_rdy_wait: gaps must be at least one cycle");
   end

   wait_phase_t     phase;
   logic [GW-1:0]   gcnt;
   logic [TO_W-1:0] wcnt;
   logic [TO_W-1:0] wcnt_next;

   assign ok        = (phase == W_SAMP) && rb;
   assign tout      = (phase == W_SAMP) && !rb && (wcnt >= limit);
   assign wcnt_next = (wcnt != '1) ? wcnt + 1'b1 : wcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= W_OFF;
         gcnt  <= '0;
         wcnt  <= '0;
      end else if (start) begin
         phase <= W_PRE;
         gcnt  <= GW'(PRE_GAP - 1);
         wcnt  <= '0;
      end else begin
         case (phase)
            W_PRE: begin
               wcnt <= wcnt_next;
               if (gcnt == '0) phase <= W_SAMP;
               else            gcnt  <= gcnt - 1'b1;
            end
            W_SAMP: begin
               wcnt <= wcnt_next;
               if (ok || tout) begin
                  phase <= W_OFF;
               end else begin
                  phase <= W_GAP;
                  gcnt  <= GW'(POLL_GAP - 1);
               end
            end
            W_GAP: begin
               wcnt <= wcnt_next;
               if (gcnt == '0) phase <= W_SAMP;
               else            gcnt  <= gcnt - 1'b1;
            end
            default: phase <= W_OFF;
         endcase
      end
   end

   // R8: completion only on a ready sample
   a_r8_ok_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> rb);
   // R8: a busy sample that does not time out is followed by an idle gap
   a_r8_busy_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == W_SAMP && !rb && !tout && !start) |=> (phase == W_GAP));
   // R9: timeout only ever on a busy device
   a_r9_tout_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tout |-> !rb);
   // R9: elapsed wait count never goes backwards while waiting
   a_r9_wcnt_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != W_OFF && !start) |=> (wcnt >= $past(wcnt)));
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
   parameter int OFS_W          = 24,
   parameter int FLAG_W         = 2,
   parameter int TO_W           = 32,
   parameter int LATCH_PRE_GAP  = 4,
   parameter int LATCH_POST_GAP = 4,
   parameter int RDY_PRE_GAP    = 4,
   parameter int RDY_POLL_GAP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_addr,
   input  logic [7:0]        req_cmd,
   input  logic [OFS_W-1:0]  req_ofs,
   input  logic [1:0]        req_mode,
   input  logic [FLAG_W-1:0] req_flags_latch,
   input  logic [FLAG_W-1:0] req_flags_release,
   input  logic [TO_W-1:0]   rdy_timeout_cycles,
   output logic              done,
   output logic              timeout,
   output logic              rejected,
   output logic              nand_ce,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we,
   output logic              nand_pipe_term,
   output logic [7:0]        nand_dq,
   output logic [FLAG_W-1:0] nand_flags,
   input  logic              nand_rb
);
   import nseq_pkg::*;

   localparam int GAP_MAX = (LATCH_PRE_GAP > LATCH_POST_GAP) ? LATCH_PRE_GAP : LATCH_POST_GAP;
   localparam int GAP_W   = $clog2(GAP_MAX + 1);

   if (LATCH_PRE_GAP < 1 || LATCH_POST_GAP < 1) begin : g_bad_gap
      $error("nand_cmd_seq: latch gaps must be at least one cycle");
   end
   if (FLAG_W < 1 || TO_W < 2) begin : g_bad_w
      $error("nand_cmd_seq: FLAG_W and TO_W too small");
   end

   seq_state_t        state, nxt;
   logic              accept, reject_now;
   logic              c_is_addr;
   logic [7:0]        c_cmd;
   logic [OFS_W-1:0]  c_ofs;
   logic [1:0]        c_mode;
   logic [FLAG_W-1:0] c_fl, c_fr;
   logic [1:0]        idx;
   logic              gap_load, gap_exp;
   logic [GAP_W-1:0]  gap_len_m1;
   logic              wait_start, wait_ok, wait_tout;
   logic [7:0]        pick_byte;
   logic [1:0]        pick_last;
   logic              latch_phase, rel_phase;

   assign req_ready  = (state == S_IDLE);
   assign accept     = req_valid && req_ready;
   assign reject_now = req_is_addr && !mode_valid(req_mode);

   always_comb begin
      nxt = state;
      case (state)
         S_IDLE:  if (accept) nxt = reject_now ? S_REJ : S_PRE;
         S_PRE:   if (gap_exp) nxt = S_BYTE;
         S_BYTE:  if (idx == pick_last) nxt = S_TERM;
         S_TERM:  nxt = S_POST;
         S_POST:  if (gap_exp) nxt = c_is_addr ? S_FIN : S_WAIT;
         S_WAIT: begin
            if (wait_ok)        nxt = S_FIN;
            else if (wait_tout) nxt = S_TOUT;
         end
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         c_is_addr <= 1'b0;
         c_cmd     <= '0;
         c_ofs     <= '0;
         c_mode    <= MODE_NONE;
         c_fl      <= '0;
         c_fr      <= '0;
         idx       <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            c_is_addr <= req_is_addr;
            c_cmd     <= req_cmd;
            c_ofs     <= req_ofs;
            c_mode    <= req_mode;
            c_fl      <= req_flags_latch;
            c_fr      <= req_flags_release;
            idx       <= '0;
         end else if (state == S_BYTE && idx != pick_last) begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign gap_load   = (accept && !reject_now) || (state == S_TERM);
   assign gap_len_m1 = (state == S_TERM) ? GAP_W'(LATCH_POST_GAP - 1)
                                         : GAP_W'(LATCH_PRE_GAP - 1);
   assign wait_start = (state == S_POST) && gap_exp && !c_is_addr;

   nseq_gap_timer #(.CNT_W(GAP_W)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (gap_load),
      .len_m1  (gap_len_m1),
      .expired (gap_exp)
   );

   nseq_addr_pick #(.OFS_W(OFS_W)) u_pick (
      .is_addr  (c_is_addr),
      .cmd      (c_cmd),
      .ofs      (c_ofs),
      .mode     (c_mode),
      .idx      (idx),
      .byte_out (pick_byte),
      .last_idx (pick_last)
   );

   nseq_rdy_wait #(
      .PRE_GAP  (RDY_PRE_GAP),
      .POLL_GAP (RDY_POLL_GAP),
      .TO_W     (TO_W)
   ) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wait_start),
      .rb    (nand_rb),
      .limit (rdy_timeout_cycles),
      .ok    (wait_ok),
      .tout  (wait_tout)
   );

   assign latch_phase    = (state == S_PRE) || (state == S_BYTE) || (state == S_TERM);
   assign rel_phase      = (state == S_POST) || (state == S_WAIT);
   assign nand_ce        = latch_phase || rel_phase;
   assign nand_cle       = latch_phase && !c_is_addr;
   assign nand_ale       = latch_phase && c_is_addr;
   assign nand_we        = (state == S_BYTE) || (state == S_TERM);
   assign nand_pipe_term = (state == S_TERM);
   assign nand_dq        = (state == S_BYTE) ? pick_byte : TERM_BYTE;
   assign nand_flags     = latch_phase ? c_fl :
                           rel_phase   ? (c_fl | (c_is_addr ? c_fr : '0)) : '0;
   assign done           = (state == S_FIN);
   assign timeout        = (state == S_TOUT);
   assign rejected       = (state == S_REJ);

   // R12: strobe only with enable and an active latch line
   a_r12_we_in_latch: assert property (@(posedge clk) disable iff (!rst_n)
      nand_we |-> (nand_ce && (nand_cle || nand_ale)));
   // R2: command and address latches never overlap
   a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   // R2: the terminating write carries zero on the bus
   a_r2_term_zero: assert property (@(posedge clk) disable iff (!rst_n)
      nand_pipe_term |-> (nand_we && nand_dq == 8'h00));
   // R3: the latch falls right after the terminating write, enable held
   a_r3_term_then_release: assert property (@(posedge clk) disable iff (!rst_n)
      nand_pipe_term |=> (nand_ce && !nand_cle && !nand_ale && !nand_we));
   // R3: address operations never enter the ready wait
   a_r3_addr_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT) |-> !c_is_addr);
   // R7: a rejection comes straight from idle with the bus untouched
   a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rejected |-> (!nand_ce && $past(req_ready)));
   // R11: result pulses are mutually exclusive
   a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, timeout, rejected}));
   // R11: a result pulse lasts one cycle and frees the host port
   a_r11_result_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (done || timeout || rejected) |=> (req_ready && !done && !timeout && !rejected));
endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_is_addr = 1'b0;
   logic [7:0]  req_cmd = '0;
   logic [23:0] req_ofs = '0;
   logic [1:0]  req_mode = '0;
   logic [1:0]  req_flags_latch = '0;
   logic [1:0]  req_flags_release = '0;
   logic [31:0] rdy_timeout_cycles = 32'd1000;
   logic        done, timeout, rejected;
   logic        nand_ce, nand_cle, nand_ale, nand_we, nand_pipe_term;
   logic [7:0]  nand_dq;
   logic [1:0]  nand_flags;
   logic        nand_rb = 1'b1;

   int tests = 0;
   int fails = 0;

   // per-operation trace
   int         nb, term_cnt, term_bad, pre_idle, post_idle, flag_bad, we_bad, busy_bad;
   int         end_kind, end_cyc, after_bad;
   bit         cle_seen, ale_seen, ce_seen;
   logic [7:0] bytes_q [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_cmd_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_is_addr(req_is_addr),
      .req_cmd(req_cmd), .req_ofs(req_ofs), .req_mode(req_mode),
      .req_flags_latch(req_flags_latch), .req_flags_release(req_flags_release),
      .rdy_timeout_cycles(rdy_timeout_cycles),
      .done(done), .timeout(timeout), .rejected(rejected),
      .nand_ce(nand_ce), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we(nand_we),
      .nand_pipe_term(nand_pipe_term), .nand_dq(nand_dq), .nand_flags(nand_flags),
      .nand_rb(nand_rb)
   );

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected finished");
      summary();
      $finish;
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // sample index i of the wait is visible as a result two cycles after cycle 10+i-1
   function automatic int tout_cycle(input int lim);
      int i = 4;
      while (i < lim) i += 3;
      return 11 + i;
   endfunction

   task automatic run_op(input bit is_addr, input logic [7:0] cmd, input logic [23:0] ofs,
                         input logic [1:0] mode, input logic [1:0] fl, input logic [1:0] fr,
                         input logic [31:0] lim, input bit rb0, input int rise_cyc);
      logic [1:0] exp_post;
      exp_post = is_addr ? (fl | fr) : fl;
      nb = 0; term_cnt = 0; term_bad = 0; pre_idle = 0; post_idle = 0; flag_bad = 0;
      we_bad = 0; busy_bad = 0; end_kind = 0; end_cyc = -1; after_bad = 0;
      cle_seen = 0; ale_seen = 0; ce_seen = 0;
      for (int k = 0; k < 4; k++) bytes_q[k] = '0;
      @(negedge clk);
      req_is_addr = is_addr; req_cmd = cmd; req_ofs = ofs; req_mode = mode;
      req_flags_latch = fl; req_flags_release = fr; rdy_timeout_cycles = lim;
      nand_rb = rb0; req_valid = 1'b1;
      @(posedge clk);
      for (int c = 0; c < 400 && end_kind == 0; c++) begin
         @(negedge clk);
         if (c == 0) req_valid = 1'b0;
         if (req_ready) busy_bad++;
         if (nand_cle) cle_seen = 1;
         if (nand_ale) ale_seen = 1;
         if (nand_ce)  ce_seen = 1;
         if ((nand_cle || nand_ale) && !nand_we && nb == 0 && term_cnt == 0) pre_idle++;
         if (nand_we && !nand_pipe_term) begin
            if (nb < 4) bytes_q[nb] = nand_dq;
            nb++;
         end
         if (nand_pipe_term) begin
            term_cnt++;
            if (nand_dq != 8'h00 || !(nand_cle || nand_ale)) term_bad++;
         end
         if (nand_we && !(nand_ce && (nand_cle || nand_ale))) we_bad++;
         if (nand_ce && !nand_cle && !nand_ale) begin
            post_idle++;
            if (nand_flags != exp_post) flag_bad++;
         end
         if ((nand_cle || nand_ale) && nand_flags != fl) flag_bad++;
         if (!nand_ce && nand_flags != 2'b00) flag_bad++;
         if (done)          begin end_kind = 1; end_cyc = c; end
         else if (timeout)  begin end_kind = 2; end_cyc = c; end
         else if (rejected) begin end_kind = 3; end_cyc = c; end
         if (c == rise_cyc) nand_rb = 1'b1;
      end
      if (end_kind != 0) begin
         @(negedge clk);
         if (!req_ready || done || timeout || rejected || nand_ce) after_bad = 1;
      end
      nand_rb = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1", "req_ready after reset", req_ready, 1);
      chk("R1", "ce/cle/ale/we/term idle", {nand_ce, nand_cle, nand_ale, nand_we, nand_pipe_term}, 0);
      chk("R1", "result pulses idle", {done, timeout, rejected}, 0);
   endtask

   task automatic t_command();
      run_op(0, 8'h90, 24'h0, 2'd0, 2'b01, 2'b10, 32'd1000, 1'b1, -1);
      chk("R2", "cle used, ale unused", {cle_seen, ale_seen}, 2'b10);
      chk("R2", "idle cycles before byte", pre_idle, 4);
      chk("R2", "byte count", nb, 1);
      chk("R2", "command byte", bytes_q[0], 8'h90);
      chk("R2", "single zero terminate", {term_cnt, term_bad}, {32'd1, 32'd0});
      chk("R12", "strobe outside latch", we_bad, 0);
      chk("R8", "done cycle with device ready", {end_kind, end_cyc}, {32'd1, 32'd15});
      chk("R3", "released enable cycles incl. wait", post_idle, 9);
      chk("R10", "command flags (release set ignored)", flag_bad, 0);
      chk("R11", "host held off while busy", busy_bad, 0);
      chk("R11", "single-cycle done then ready", after_bad, 0);
   endtask

   task automatic t_addr_mode1();
      run_op(1, 8'h00, 24'hABCDEF, 2'd1, 2'b01, 2'b10, 32'd1000, 1'b0, -1);
      chk("R4", "ale used, cle unused", {cle_seen, ale_seen}, 2'b01);
      chk("R4", "mode1 byte", {nb, 24'(bytes_q[0])}, {32'd1, 24'hEF});
      chk("R3", "address done cycle, no wait on busy", {end_kind, end_cyc}, {32'd1, 32'd10});
      chk("R3", "release idle cycles", post_idle, 4);
      chk("R10", "latch and ORed release flags", flag_bad, 0);
   endtask

   task automatic t_addr_mode2();
      logic [23:0] o;
      o = 24'hABCDEF;
      run_op(1, 8'h00, o, 2'd2, 2'b00, 2'b11, 32'd1000, 1'b1, -1);
      chk("R5", "mode2 byte count", nb, 2);
      chk("R5", "mode2 first byte bits 16:9", bytes_q[0], (o >> 9) & 24'hFF);
      chk("R5", "mode2 second byte bits 23:17", bytes_q[1], (o >> 17) & 24'h7F);
      chk("R5", "mode2 done cycle", end_cyc, 11);
      run_op(1, 8'h00, 24'h000100, 2'd2, 2'b00, 2'b00, 32'd1000, 1'b1, -1);
      chk("R5", "bit 8 alone gives zero bytes", {bytes_q[0], bytes_q[1]}, 16'h0000);
   endtask

   task automatic t_addr_mode3();
      logic [23:0] o;
      o = 24'h123456;
      run_op(1, 8'h00, o, 2'd3, 2'b10, 2'b01, 32'd1000, 1'b1, -1);
      chk("R6", "mode3 byte count", nb, 3);
      chk("R6", "mode3 bytes in order", {bytes_q[0], bytes_q[1], bytes_q[2]},
          {o[7:0], o[16:9], 1'b0, o[23:17]});
      chk("R6", "mode3 done cycle", end_cyc, 12);
      chk("R10", "mode3 flags", flag_bad, 0);
      run_op(1, 8'h00, 24'h000100, 2'd3, 2'b00, 2'b00, 32'd1000, 1'b1, -1);
      chk("R5", "bit 8 dropped in mode3", {bytes_q[0], bytes_q[1], bytes_q[2]}, 24'h0);
   endtask

   task automatic t_reject();
      run_op(1, 8'h00, 24'hFFFFFF, 2'd0, 2'b11, 2'b11, 32'd1000, 1'b1, -1);
      chk("R7", "reject pulse cycle", {end_kind, end_cyc}, {32'd3, 32'd0});
      chk("R7", "no enable or strobe", {ce_seen, cle_seen, ale_seen, 32'(nb), 32'(term_cnt)}, 0);
      chk("R11", "ready after reject", after_bad, 0);
   endtask

   task automatic t_late_ready();
      run_op(0, 8'h70, 24'h0, 2'd0, 2'b00, 2'b00, 32'd1000, 1'b0, 20);
      chk("R8", "done after first ready sample", {end_kind, end_cyc}, {32'd1, 32'd21});
      chk("R8", "enable held through wait", post_idle, 4 + 11);
   endtask

   task automatic t_timeout();
      run_op(0, 8'hFF, 24'h0, 2'd0, 2'b01, 2'b00, 32'd20, 1'b0, -1);
      chk("R9", "timeout at budget 20", {end_kind, end_cyc}, {32'd2, 32'(tout_cycle(20))});
      chk("R11", "ready after timeout", after_bad, 0);
      run_op(0, 8'hFF, 24'h0, 2'd0, 2'b01, 2'b00, 32'd0, 1'b0, -1);
      chk("R9", "timeout at budget 0", {end_kind, end_cyc}, {32'd2, 32'(tout_cycle(0))});
      run_op(0, 8'hFF, 24'h0, 2'd0, 2'b01, 2'b00, 32'd7, 1'b0, -1);
      chk("R9", "timeout at budget on sample point", {end_kind, end_cyc}, {32'd2, 32'(tout_cycle(7))});
      run_op(0, 8'h90, 24'h0, 2'd0, 2'b01, 2'b00, 32'd0, 1'b1, -1);
      chk("R8", "ready wins over zero budget", {end_kind, end_cyc}, {32'd1, 32'd15});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_command();
      t_addr_mode1();
      t_addr_mode2();
      t_addr_mode3();
      t_reject();
      t_late_ready();
      t_timeout();
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end
endmodule